// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Sequencer

This block drives the command strobes of a single DRAM bank that owns one row buffer. It takes one request at a time: a row address, a column address and a read/write flag. It compares the requested row with the row currently held in the buffer and sorts the access into one of three kinds. A hit needs only the column phase. An empty-buffer access needs an activate and then the column phase. A conflict needs a precharge, an activate and then the column phase. Each phase lasts a fixed number of clock cycles, set by a parameter.

After the column phase, the page policy decides what happens to the row. With the open-page setting the row stays in the buffer. With the close-page setting the bank precharges at once and the buffer becomes empty. A parameter chooses whether the policy comes from a pin or is fixed to one setting.

An internal interval counter makes a refresh due at a fixed rate. The refresh waits for any running access to finish. If a row is open, the bank precharges it first. The bank then holds busy for the refresh time and leaves the buffer empty. The requester offers work only while busy is low, and a request is taken on the first clock edge at which it is offered with busy low.

Top module: `dram_bank_ctrl`

## Requirements
- R1: While reset is held and right after it is released, busy, done and every command strobe are low and acc_class reads 00.
- R2: A request to the row already open is a hit. It issues only a column strobe in cycle 1 after acceptance, and done pulses with acc_class = 01 in cycle PHASE_CYC (cycle 2 by default).
- R3: A request while no row is open issues an activate strobe in cycle 1 and a column strobe in cycle PHASE_CYC+1. Done pulses with acc_class = 10 in cycle 2*PHASE_CYC.
- R4: A request to a row other than the open row issues a precharge, then an activate, then a column strobe, each PHASE_CYC cycles apart. Done pulses with acc_class = 11 in cycle 3*PHASE_CYC.
- R5: cmd_addr carries the requested row in the cycle of the activate strobe and the requested column in the cycle of the column strobe.
- R6: The column strobe is cmd_wr when req_write is 1 and cmd_rd when it is 0. At most one of the five command strobes is high in any cycle.
- R7: Under the open-page policy (page_close = 0 at acceptance) the row stays open, and busy is low in the cycle after done.
- R8: Under the close-page policy (page_close = 1 at acceptance) a precharge strobe follows in the cycle after done. Busy stays high for PHASE_CYC more cycles, and the next access finds the buffer empty.
- R9: A request offered while busy is high is ignored. It issues no command and does not change the open row.
- R10: Once every REF_INTERVAL cycles a refresh becomes due. The refresh strobe never appears between the acceptance of an access and its done pulse. With an empty buffer the refresh strobe comes with no precharge before it.
- R11: A refresh with a row open issues a precharge strobe exactly PHASE_CYC cycles before the refresh strobe. Busy then stays high for REF_CYC cycles from the refresh strobe, and the next access is classed empty.
- R12: acc_class reads 00 in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| page_close | input | 1 | 1 = close-page policy for this request (pin-selected variant) |
| busy | output | 1 | Bank busy or refresh due; requests are not taken |
| done | output | 1 | One-cycle pulse in the last cycle of the column phase |
| acc_class | output | 2 | 01 hit, 10 empty, 11 conflict while done is high; else 00 |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_act | output | 1 | Activate strobe |
| cmd_rd | output | 1 | Read column strobe |
| cmd_wr | output | 1 | Write column strobe |
| cmd_ref | output | 1 | Refresh strobe |
| cmd_addr | output | max(ROW_W,COL_W) | Row with activate, column with read/write, else zero |

## Verification
The hardest situation to reach from the ports is a refresh that falls due while a row is still open. The bench must then see the extra precharge at its exact spacing, the full refresh hold and the empty buffer that follows. The interval counter starts at reset release, so the bench first runs all its vector traffic well inside the first interval. It ends on a conflict access that leaves a row open, then waits for the refresh and measures the strobe spacing. It then closes the row with a close-page access, waits for the second refresh and checks that no precharge comes before it. Ignored requests are produced by holding a request for a different row on the inputs during a long access and dropping it just before busy falls.

// File: rtl/bank_pkg.sv
package bank_pkg;

   typedef enum logic [1:0] {
      ACC_NONE     = 2'b00,
      ACC_HIT      = 2'b01,
      ACC_EMPTY    = 2'b10,
      ACC_CONFLICT = 2'b11
   } acc_class_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_COL,
      ST_CPRE,
      ST_RPRE,
      ST_REF
   } seq_state_t;

endpackage

// File: rtl/bank_refresh_timer.sv
module bank_refresh_timer #(
   parameter int INTERVAL = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_taken,
   output logic ref_due
);
   localparam int W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

   if (INTERVAL < 2) begin : g_bad_interval
      $error("bank_refresh_timer: INTERVAL must be at least 2");
   end

   logic [W-1:0] tick_cnt;
   logic         pend_q;
   logic         tick;

   assign tick = (tick_cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
         pend_q   <= 1'b0;
      end else begin
         tick_cnt <= tick ? '0 : tick_cnt + W'(1);
         if (tick)
            pend_q <= 1'b1;
         else if (ref_taken)
            pend_q <= 1'b0;
      end
   end

   assign ref_due = pend_q;

   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cnt <= LAST)
      else $error("refresh counter beyond interval");

   assert_due_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ref_due)
      else $error("refresh not flagged after interval");

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
   import bank_pkg::*;
#(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             open_clr,
   input  logic [ROW_W-1:0] set_row,
   input  logic [ROW_W-1:0] probe_row,
   output logic             row_open,
   output acc_class_t       probe_class
);
   logic             open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (open_set) begin
         open_q <= 1'b1;
         row_q  <= set_row;
      end else if (open_clr) begin
         open_q <= 1'b0;
      end
   end

   always_comb begin
      if (!open_q)
         probe_class = ACC_EMPTY;
      else if (row_q == probe_row)
         probe_class = ACC_HIT;
      else
         probe_class = ACC_CONFLICT;
   end

   assign row_open = open_q;

   assert_no_set_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_set && open_clr))
      else $error("row buffer opened and closed together");

   assert_set_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      open_set |=> row_open)
      else $error("activate did not open the row");

   assert_clr_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      open_clr |=> !row_open)
      else $error("precharge did not empty the row buffer");

endmodule

// File: rtl/bank_sequencer.sv
module bank_sequencer
   import bank_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 12,
   parameter int PHASE_CYC = 2,
   parameter int REF_CYC   = 8
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   input  logic [ROW_W-1:0]                          req_row,
   input  logic [COL_W-1:0]                          req_col,
   input  logic                                      req_write,
   input  logic                                      close_sel,
   input  logic                                      ref_due,
   input  logic                                      row_open,
   input  acc_class_t                                probe_class,
   output logic                                      open_set,
   output logic                                      open_clr,
   output logic [ROW_W-1:0]                          set_row,
   output logic                                      ref_taken,
   output logic                                      busy,
   output logic                                      done,
   output acc_class_t                                acc_class,
   output logic                                      cmd_pre,
   output logic                                      cmd_act,
   output logic                                      cmd_rd,
   output logic                                      cmd_wr,
   output logic                                      cmd_ref,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr
);
   localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int MAX_LEN = (PHASE_CYC > REF_CYC) ? PHASE_CYC : REF_CYC;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PHASE_CYC - 1);
   localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_CYC - 1);

   seq_state_t       state, nxt;
   logic [CNT_W-1:0] cnt, nxt_cnt;
   logic             first;
   logic             go;
   logic             accept;
   logic [ROW_W-1:0] lat_row;
   logic [COL_W-1:0] lat_col;
   logic             lat_we;
   logic             lat_close;
   acc_class_t       lat_cls;
   logic             phase_end;

   assign phase_end = (cnt == '0);
   assign accept    = (state == ST_IDLE) && !ref_due && req_valid;

   always_comb begin
      nxt       = state;
      go        = 1'b0;
      open_set  = 1'b0;
      open_clr  = 1'b0;
      ref_taken = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (ref_due) begin
               ref_taken = 1'b1;
               go        = 1'b1;
               nxt       = row_open ? ST_RPRE : ST_REF;
            end else if (req_valid) begin
               go = 1'b1;
               unique case (probe_class)
                  ACC_HIT:   nxt = ST_COL;
                  ACC_EMPTY: nxt = ST_ACT;
                  default:   nxt = ST_PRE;
               endcase
            end
         end
         ST_PRE: begin
            if (phase_end) begin
               open_clr = 1'b1;
               go       = 1'b1;
               nxt      = ST_ACT;
            end
         end
         ST_ACT: begin
            if (phase_end) begin
               open_set = 1'b1;
               go       = 1'b1;
               nxt      = ST_COL;
            end
         end
         ST_COL: begin
            if (phase_end) begin
               go  = 1'b1;
               nxt = lat_close ? ST_CPRE : ST_IDLE;
            end
         end
         ST_CPRE: begin
            if (phase_end) begin
               open_clr = 1'b1;
               go       = 1'b1;
               nxt      = ST_IDLE;
            end
         end
         ST_RPRE: begin
            if (phase_end) begin
               open_clr = 1'b1;
               go       = 1'b1;
               nxt      = ST_REF;
            end
         end
         ST_REF: begin
            if (phase_end) begin
               go  = 1'b1;
               nxt = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      if (go) begin
         if (nxt == ST_REF)
            nxt_cnt = REF_LAST;
         else if (nxt == ST_IDLE)
            nxt_cnt = '0;
         else
            nxt_cnt = PH_LAST;
      end else if (!phase_end) begin
         nxt_cnt = cnt - CNT_W'(1);
      end else begin
         nxt_cnt = cnt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         first     <= 1'b0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_we    <= 1'b0;
         lat_close <= 1'b0;
         lat_cls   <= ACC_NONE;
      end else begin
         state <= nxt;
         cnt   <= nxt_cnt;
         first <= go && (nxt != ST_IDLE);
         if (accept) begin
            lat_row   <= req_row;
            lat_col   <= req_col;
            lat_we    <= req_write;
            lat_close <= close_sel;
            lat_cls   <= probe_class;
         end
      end
   end

   assign set_row   = lat_row;
   assign busy      = (state != ST_IDLE) || ref_due;
   assign done      = (state == ST_COL) && phase_end;
   assign acc_class = done ? lat_cls : ACC_NONE;

   assign cmd_pre = first && ((state == ST_PRE) || (state == ST_CPRE) || (state == ST_RPRE));
   assign cmd_act = first && (state == ST_ACT);
   assign cmd_rd  = first && (state == ST_COL) && !lat_we;
   assign cmd_wr  = first && (state == ST_COL) && lat_we;
   assign cmd_ref = first && (state == ST_REF);

   always_comb begin
      if (state == ST_ACT)
         cmd_addr = ADDR_W'(lat_row);
      else if (state == ST_COL)
         cmd_addr = ADDR_W'(lat_col);
      else
         cmd_addr = '0;
   end

   assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref}))
      else $error("more than one command strobe");

   assert_ref_outside_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ref) |-> ($past(state) == ST_IDLE || $past(state) == ST_RPRE))
      else $error("refresh started inside an access");

   assert_hit_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (first && state == ST_COL && lat_cls == ACC_HIT) |-> ($past(state) == ST_IDLE))
      else $error("hit went through extra phases");

   assert_col_row_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COL) |-> row_open)
      else $error("column phase with no open row");

   assert_close_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lat_close) |=> cmd_pre)
      else $error("close-page access not followed by precharge");

   assert_open_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !lat_close) |=> (state == ST_IDLE && row_open))
      else $error("open-page access did not return to idle with row open");

   assert_class_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (acc_class == ACC_NONE))
      else $error("class output active without done");

endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
   import bank_pkg::*;
#(
   parameter int ROW_W        = 12,
   parameter int COL_W        = 12,
   parameter int PHASE_CYC    = 2,
   parameter int REF_CYC      = 8,
   parameter int REF_INTERVAL = 780,
   parameter int POLICY       = 0
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   input  logic [ROW_W-1:0]                          req_row,
   input  logic [COL_W-1:0]                          req_col,
   input  logic                                      req_write,
   input  logic                                      page_close,
   output logic                                      busy,
   output logic                                      done,
   output logic [1:0]                                acc_class,
   output logic                                      cmd_pre,
   output logic                                      cmd_act,
   output logic                                      cmd_rd,
   output logic                                      cmd_wr,
   output logic                                      cmd_ref,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr
);
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("dram_bank_ctrl: address widths must be positive");
   end
   if (PHASE_CYC < 1 || REF_CYC < 1) begin : g_bad_phase
      $error("dram_bank_ctrl: phase and refresh lengths must be positive");
   end
   if (REF_INTERVAL <= 3 * PHASE_CYC + REF_CYC) begin : g_bad_interval
      $error("dram_bank_ctrl: refresh interval too short for one access plus refresh");
   end

   logic close_sel;

   if (POLICY == 0) begin : g_policy_pin
      assign close_sel = page_close;
   end else if (POLICY == 1) begin : g_policy_open
      assign close_sel = 1'b0;
   end else if (POLICY == 2) begin : g_policy_close
      assign close_sel = 1'b1;
   end else begin : g_policy_bad
      $error("dram_bank_ctrl: POLICY must be 0, 1 or 2");
   end

   logic             ref_due;
   logic             ref_taken;
   logic             row_open;
   logic             open_set;
   logic             open_clr;
   logic [ROW_W-1:0] set_row;
   acc_class_t       probe_class;
   acc_class_t       seq_class;
   logic [ADDR_W-1:0] seq_addr;

   bank_refresh_timer #(
      .INTERVAL (REF_INTERVAL)
   ) u_refresh (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_taken (ref_taken),
      .ref_due   (ref_due)
   );

   bank_row_tracker #(
      .ROW_W (ROW_W)
   ) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .open_set    (open_set),
      .open_clr    (open_clr),
      .set_row     (set_row),
      .probe_row   (req_row),
      .row_open    (row_open),
      .probe_class (probe_class)
   );

   bank_sequencer #(
      .ROW_W     (ROW_W),
      .COL_W     (COL_W),
      .PHASE_CYC (PHASE_CYC),
      .REF_CYC   (REF_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_row     (req_row),
      .req_col     (req_col),
      .req_write   (req_write),
      .close_sel   (close_sel),
      .ref_due     (ref_due),
      .row_open    (row_open),
      .probe_class (probe_class),
      .open_set    (open_set),
      .open_clr    (open_clr),
      .set_row     (set_row),
      .ref_taken   (ref_taken),
      .busy        (busy),
      .done        (done),
      .acc_class   (seq_class),
      .cmd_pre     (cmd_pre),
      .cmd_act     (cmd_act),
      .cmd_rd      (cmd_rd),
      .cmd_wr      (cmd_wr),
      .cmd_ref     (cmd_ref),
      .cmd_addr    (seq_addr)
   );

   assign acc_class = seq_class;
   assign cmd_addr  = seq_addr;

   assert_busy_during_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ref |-> busy)
      else $error("refresh with busy low");

   assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy)
      else $error("done outside a busy access");

endmodule

// File: tb/dram_bank_ctrl_test.sv
module dram_bank_ctrl_test;
   localparam int ROW_W   = 12;
   localparam int COL_W   = 12;
   localparam int PH      = 2;
   localparam int RC      = 8;
   localparam int RINT    = 2000;
   localparam int NVEC    = 12;

   // vector: {row, col, write, close, expected class}
   localparam logic [27:0] VEC [0:NVEC-1] = '{
      {12'd5,    12'd1,    1'b0, 1'b0, 2'b10},
      {12'd5,    12'd2,    1'b1, 1'b0, 2'b01},
      {12'd5,    12'd3,    1'b0, 1'b0, 2'b01},
      {12'd9,    12'd4,    1'b1, 1'b0, 2'b11},
      {12'd9,    12'hFFF,  1'b0, 1'b1, 2'b01},
      {12'd9,    12'd7,    1'b0, 1'b0, 2'b10},
      {12'hFFF,  12'd0,    1'b1, 1'b0, 2'b11},
      {12'hFFF,  12'd8,    1'b0, 1'b1, 2'b01},
      {12'd0,    12'd9,    1'b0, 1'b1, 2'b10},
      {12'd0,    12'd10,   1'b1, 1'b0, 2'b10},
      {12'd0,    12'd11,   1'b0, 1'b0, 2'b01},
      {12'd1,    12'd12,   1'b1, 1'b0, 2'b11}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic             req_write = 1'b0;
   logic             page_close = 1'b0;
   logic             busy, done, cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref;
   logic [1:0]       acc_class;
   logic [11:0]      cmd_addr;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_bank_ctrl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .PHASE_CYC(PH), .REF_CYC(RC),
      .REF_INTERVAL(RINT), .POLICY(0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
      .req_col(req_col), .req_write(req_write), .page_close(page_close),
      .busy(busy), .done(done), .acc_class(acc_class), .cmd_pre(cmd_pre),
      .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_ref(cmd_ref),
      .cmd_addr(cmd_addr)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // strobe codes: 1 pre, 2 act, 3 rd, 4 wr, 5 ref
   task automatic run_req(input logic [11:0] row, input logic [11:0] col, input logic we,
                          input logic cl, input logic [1:0] exp_cls, input bit noise);
      int seq = 0;
      int got_n = 0;
      int exp_n;
      int exp_seq;
      int colc;
      logic [1:0] got_cls = 2'b00;
      string tag;
      colc = we ? 4 : 3;
      case (exp_cls)
         2'b01: begin tag = "R2 hit";      exp_n = PH;     exp_seq = colc; end
         2'b10: begin tag = "R3 empty";    exp_n = 2 * PH; exp_seq = 2 * 8 + colc; end
         default: begin tag = "R4 conflict"; exp_n = 3 * PH; exp_seq = (1 * 8 + 2) * 8 + colc; end
      endcase
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_row = row; req_col = col; req_write = we; page_close = cl;
      @(negedge clk);
      if (noise) req_row = row ^ 12'h800;
      else req_valid = 1'b0;
      for (int n = 1; n <= 20; n++) begin
         if (cmd_pre) seq = seq * 8 + 1;
         if (cmd_act) begin
            seq = seq * 8 + 2;
            chk(cmd_addr == row, "R5 row on activate", cmd_addr, row);
         end
         if (cmd_rd) seq = seq * 8 + 3;
         if (cmd_wr) seq = seq * 8 + 4;
         if (cmd_rd || cmd_wr)
            chk(cmd_addr == col, "R5 column on column strobe", cmd_addr, col);
         if (cmd_ref) seq = seq * 8 + 5;
         if (done) begin
            got_n = n;
            got_cls = acc_class;
            req_valid = 1'b0;
            break;
         end
         chk(acc_class == 2'b00, "R12 class quiet without done", acc_class, 0);
         @(negedge clk);
      end
      chk(got_n == exp_n, {tag, " latency"}, got_n, exp_n);
      chk(got_cls == exp_cls, {tag, " class"}, got_cls, exp_cls);
      chk(seq == exp_seq, {tag, " strobe order R6 R10"}, seq, exp_seq);
      @(negedge clk);
      if (cl) begin
         chk(cmd_pre && busy, "R8 precharge after close-page access", {cmd_pre, busy}, 3);
         for (int k = 1; k < PH; k++) @(negedge clk);
         chk(busy, "R8 busy through close precharge", busy, 1);
         @(negedge clk);
         chk(!busy, "R8 idle after close precharge", busy, 0);
      end else begin
         chk(!busy && !cmd_pre, noise ? "R9 busy request ignored" : "R7 open-page idle after done",
             {busy, cmd_pre}, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=%0d expected=finish", cyc);
      finish_run();
   end

   initial begin
      int ref_cyc1 = 0;
      int ref_cyc2 = 0;
      int pre_cyc = -100;
      bit pre_seen = 1'b0;
      bit got;
      repeat (3) @(negedge clk);
      chk({busy, done, cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref} == 7'b0 && acc_class == 2'b00,
          "R1 outputs during reset", {busy, done, cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref} == 7'b0 && acc_class == 2'b00,
          "R1 outputs after reset", {busy, done, cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref}, 0);

      for (int v = 0; v < NVEC; v++)
         run_req(VEC[v][27:16], VEC[v][15:4], VEC[v][3], VEC[v][2], VEC[v][1:0], 1'b0);

      // R9: request for another row held while busy, dropped before idle
      run_req(12'd1, 12'd20, 1'b0, 1'b0, 2'b01, 1'b1);
      run_req(12'd1, 12'd21, 1'b1, 1'b0, 2'b01, 1'b0);

      // R11: refresh with row 1 open
      got = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (cmd_pre) pre_cyc = cyc;
         if (cmd_ref) begin ref_cyc1 = cyc; got = 1'b1; break; end
      end
      chk(got, "R10 first refresh issued", got, 1);
      chk(ref_cyc1 - pre_cyc == PH, "R11 precharge before refresh", ref_cyc1 - pre_cyc, PH);
      for (int k = 1; k < RC; k++) @(negedge clk);
      chk(busy, "R11 busy through refresh", busy, 1);
      @(negedge clk);
      chk(!busy, "R11 idle after refresh", busy, 0);
      run_req(12'd1, 12'd22, 1'b0, 1'b1, 2'b10, 1'b0);

      // R10: second refresh with empty buffer, no precharge before it
      got = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (cmd_pre) pre_seen = 1'b1;
         if (cmd_ref) begin ref_cyc2 = cyc; got = 1'b1; break; end
      end
      chk(got && !pre_seen, "R10 refresh on empty buffer without precharge", {got, pre_seen}, 2);
      chk(ref_cyc2 - ref_cyc1 == RINT - PH, "R10 refresh period", ref_cyc2 - ref_cyc1, RINT - PH);
      for (int k = 0; k < RC; k++) @(negedge clk);
      run_req(12'd3, 12'd23, 1'b1, 1'b0, 2'b10, 1'b0);

      finish_run();
   end
endmodule